// File: doc/BRIEF.md
# Keypad Event Queue with Selectable Overflow Policy

This block holds key-press, key-release and general-input change events until a host collects them. A producer presents an 8-bit event code with a valid strobe, and marks whether the event comes from a general-purpose input or from the key matrix. The host removes the oldest stored event with a pop strobe. The code appears on a registered output one cycle later. The block reports the number of stored events, empty and full flags, and a sticky overflow flag that can feed an interrupt controller.

Two configuration inputs shape its behaviour. The first sets what happens when an event arrives while the queue is full: the newcomer is either discarded, or the oldest entry is evicted so that the newcomer fits. The second decides whether general-input events are refused while the keypad lock input is high.

An occupancy state machine has three states: `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. Its named transitions are:
- FILL_FIRST: `Q_EMPTY` to `Q_PARTIAL` on any stored push.
- FILL_LAST: `Q_PARTIAL` to `Q_FULL` on a push without a pop when one slot is free.
- DRAIN_LAST: `Q_PARTIAL` to `Q_EMPTY` on a pop without a push when one entry remains.
- DRAIN_FIRST: `Q_FULL` to `Q_PARTIAL` on a pop without a push.

In every other case the state holds. In `Q_FULL` this covers a dropped push, an evicting push and a push paired with a pop.

Top module: `evq_top`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, overflow is 0 and pop_code is 0x00.
- R2: Events are popped in the order they were stored. All 8 bits of each code return unchanged: bit 7 is the press flag (1 for press, 0 for release) and bits 6:0 are the identifier. Count rises or falls by one per stored push or pop.
- R3: With cfg_overwrite at 0, a push into a full queue is discarded. Count stays at DEPTH (10) and the stored contents stay unchanged.
- R4: With cfg_overwrite at 1, a push into a full queue removes the oldest entry and stores the new code as the newest. Count stays at DEPTH.
- R5: A push into a full queue without a simultaneous pop sets overflow in either mode. Overflow then stays set until an ovf_clear strobe. If a set and a clear fall in the same cycle, the set wins.
- R6: A pop on an empty queue yields pop_code 0x00 and leaves count at 0.
- R7: A push and a pop in the same cycle on a full queue pop the oldest entry first and then store the new code. Count stays at DEPTH and overflow is not set.
- R8: With cfg_gpi_lock_mode at 0, general-input events (push_is_gpi=1) are stored whether or not lock_active is high.
- R9: With cfg_gpi_lock_mode at 1 and lock_active high, general-input events are ignored. Key events are still stored, and general-input events are stored again once lock_active is low.
- R10: empty is 1 exactly when count is 0, full is 1 exactly when count is DEPTH, and count never exceeds DEPTH.
- R11: A push and a pop in the same cycle on an empty queue yield pop_code 0x00 and leave the pushed code stored, with count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_overwrite | input | 1 | 1: evict oldest on full; 0: drop new event |
| cfg_gpi_lock_mode | input | 1 | 1: refuse general-input events while locked |
| lock_active | input | 1 | Keypad lock state |
| push_valid | input | 1 | Event push strobe |
| push_code | input | 8 | Event code (bit 7 press flag, bits 6:0 identifier) |
| push_is_gpi | input | 1 | Pushed event comes from a general-purpose input |
| pop_req | input | 1 | Host pop strobe |
| ovf_clear | input | 1 | Write-one-to-clear strobe for overflow |
| pop_code | output | 8 | Code of the last popped event (registered) |
| count | output | 4 | Number of stored events |
| empty | output | 1 | Queue holds no events |
| full | output | 1 | Queue holds DEPTH events |
| overflow | output | 1 | Sticky overflow status |

## Verification
Every result is due in the cycle after the clock edge that samples the strobes. Count, empty, full, overflow and pop_code are all register outputs, and each is one edge behind its cause. The bench applies each stimulus 1 ns after an edge and holds it across exactly one rising edge. It reads all outputs 1 ns after that edge, before the next stimulus is applied, so every comparison falls in the cycle where the result first becomes visible. Expected codes, counts and flags come from a small ordered model in the bench. The model applies a pop before a push, and applies the drop, evict and filtering rules as the requirements state them.

// File: rtl/evq_pkg.sv
package evq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_t;
endpackage

// File: rtl/evq_filter.sv
module evq_filter (
    input  logic push_valid,
    input  logic push_is_gpi,
    input  logic gpi_lock_mode,
    input  logic lock_active,
    output logic push_acc
);
    logic gpi_blocked;

    always_comb begin
        gpi_blocked = push_is_gpi && gpi_lock_mode && lock_active;
        push_acc    = push_valid && !gpi_blocked;
    end
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl #(
    parameter int DEPTH = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_acc,
    input  logic             pop_req,
    input  logic             cfg_overwrite,
    input  logic             ovf_clear,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovf_flag,
    output logic             do_read,
    output logic             do_write,
    output logic             do_evict
);
    import evq_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    occ_t             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             space, ovf_evt;

    // operation decode: pop is taken before push
    always_comb begin
        do_read  = pop_req && (state_q != Q_EMPTY);
        space    = (state_q != Q_FULL) || do_read;
        do_write = push_acc && (space || cfg_overwrite);
        do_evict = push_acc && !space && cfg_overwrite;
        ovf_evt  = push_acc && !space;
        cnt_d    = cnt_q;
        if (do_read)
            cnt_d = cnt_d - CNT_ONE;
        if (do_write && !do_evict)
            cnt_d = cnt_d + CNT_ONE;
    end

    // next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (do_write)
                    state_d = Q_PARTIAL;                  // FILL_FIRST
            end
            Q_PARTIAL: begin
                if (cnt_q == CNT_LAST && do_write && !do_read)
                    state_d = Q_FULL;                     // FILL_LAST
                else if (cnt_q == CNT_ONE && do_read && !do_write)
                    state_d = Q_EMPTY;                    // DRAIN_LAST
            end
            Q_FULL: begin
                if (do_read && !do_write)
                    state_d = Q_PARTIAL;                  // DRAIN_FIRST
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= Q_EMPTY;
            cnt_q    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (ovf_evt)
                ovf_flag <= 1'b1;
            else if (ovf_clear)
                ovf_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        count    = cnt_q;
        is_empty = (state_q == Q_EMPTY);
        is_full  = (state_q == Q_FULL);
    end

    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty == (cnt_q == '0)); // R10
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        is_full == (cnt_q == CNT_MAX)); // R10
    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R10
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_acc && !pop_req && !cfg_overwrite) |=> (cnt_q == CNT_MAX)); // R3
    AST_EVICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_acc && !pop_req && cfg_overwrite) |=> (cnt_q == CNT_MAX)); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_acc && !pop_req) |=> ovf_flag); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_acc && pop_req && !ovf_flag) |=> !ovf_flag); // R7
    AST_POP_EMPTY_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop_req && !push_acc) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/evq_store.sv
module evq_store #(
    parameter int DEPTH = 10,
    parameter int EVT_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             do_read,
    input  logic             do_write,
    input  logic             do_evict,
    input  logic [EVT_W-1:0] wr_code,
    output logic [EVT_W-1:0] rd_code
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [EVT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_code <= '0;
        end else begin
            if (pop_req)
                rd_code <= do_read ? mem[rd_ptr] : '0;
            if (do_read || do_evict)
                rd_ptr <= ptr_inc(rd_ptr);
            if (do_write)
                wr_ptr <= ptr_inc(wr_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_write)
            mem[wr_ptr] <= wr_code;
    end

    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !do_read) |=> (rd_code == '0)); // R6
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr <= PTR_LAST) && (wr_ptr <= PTR_LAST)); // R2
    AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_read && do_evict)); // R4
endmodule

// File: rtl/evq_top.sv
module evq_top #(
    parameter int DEPTH = 10,
    parameter int EVT_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_overwrite,
    input  logic             cfg_gpi_lock_mode,
    input  logic             lock_active,
    input  logic             push_valid,
    input  logic [EVT_W-1:0] push_code,
    input  logic             push_is_gpi,
    input  logic             pop_req,
    input  logic             ovf_clear,
    output logic [EVT_W-1:0] pop_code,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    logic push_acc, do_read, do_write, do_evict;

    evq_filter u_filter (
        .push_valid    (push_valid),
        .push_is_gpi   (push_is_gpi),
        .gpi_lock_mode (cfg_gpi_lock_mode),
        .lock_active   (lock_active),
        .push_acc      (push_acc)
    );

    evq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_acc      (push_acc),
        .pop_req       (pop_req),
        .cfg_overwrite (cfg_overwrite),
        .ovf_clear     (ovf_clear),
        .count         (count),
        .is_empty      (empty),
        .is_full       (full),
        .ovf_flag      (overflow),
        .do_read       (do_read),
        .do_write      (do_write),
        .do_evict      (do_evict)
    );

    evq_store #(.DEPTH(DEPTH), .EVT_W(EVT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_req  (pop_req),
        .do_read  (do_read),
        .do_write (do_write),
        .do_evict (do_evict),
        .wr_code  (push_code),
        .rd_code  (pop_code)
    );

    AST_GPI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_is_gpi && cfg_gpi_lock_mode && lock_active && !pop_req)
        |=> $stable(count)); // R9
    AST_KEY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_is_gpi && !full && !pop_req) |=> (count != '0)); // R2
endmodule

// File: tb/tb_evq_top.sv
module tb_evq_top;
    localparam int DEPTH = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_overwrite = 1'b0, cfg_gpi_lock_mode = 1'b0, lock_active = 1'b0;
    logic       push_valid = 1'b0, push_is_gpi = 1'b0, pop_req = 1'b0, ovf_clear = 1'b0;
    logic [7:0] push_code = '0;
    logic [7:0] pop_code;
    logic [3:0] count;
    logic       empty, full, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mq [0:15];
    int         mn = 0;
    logic       m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    evq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_overwrite(cfg_overwrite),
        .cfg_gpi_lock_mode(cfg_gpi_lock_mode), .lock_active(lock_active),
        .push_valid(push_valid), .push_code(push_code), .push_is_gpi(push_is_gpi),
        .pop_req(pop_req), .ovf_clear(ovf_clear), .pop_code(pop_code),
        .count(count), .empty(empty), .full(full), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     tag, what, act, act, exp_v, exp_v);
        end
    endtask

    task automatic m_shift();
        for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
        mn--;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mn = 0;
        m_ovf = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(count == 0, "R1", "count", count, 0);
        chk(empty == 1'b1 && full == 1'b0, "R1", "empty/full", {empty, full}, 2);
        chk(overflow == 1'b0, "R1", "overflow", overflow, 0);
        chk(pop_code == 8'h00, "R1", "pop_code", pop_code, 0);
    endtask

    task automatic do_op(input logic psh, input logic [7:0] cd, input logic g,
                         input logic pp, input logic clr, input string tag);
        logic [7:0] exp_pd;
        logic       acc;
        logic       set;
        push_valid = psh; push_code = cd; push_is_gpi = g;
        pop_req = pp; ovf_clear = clr;
        @(posedge clk);
        exp_pd = 8'h00;
        if (pp && mn > 0) begin
            exp_pd = mq[0];
            m_shift();
        end
        acc = psh && !(g && cfg_gpi_lock_mode && lock_active);
        set = 1'b0;
        if (acc) begin
            if (mn < DEPTH) begin
                mq[mn] = cd; mn++;
            end else begin
                set = 1'b1;
                if (cfg_overwrite) begin
                    m_shift();
                    mq[mn] = cd; mn++;
                end
            end
        end
        m_ovf = set ? 1'b1 : (clr ? 1'b0 : m_ovf);
        #1;
        push_valid = 1'b0; pop_req = 1'b0; ovf_clear = 1'b0; push_is_gpi = 1'b0;
        chk(count == 4'(mn), tag, "count", count, mn);
        chk(empty == (mn == 0), "R10", "empty", empty, int'(mn == 0));
        chk(full == (mn == DEPTH), "R10", "full", full, int'(mn == DEPTH));
        chk(overflow == m_ovf, "R5", "overflow", overflow, m_ovf);
        if (pp)
            chk(pop_code == exp_pd, tag, "pop_code", pop_code, exp_pd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int mode = 0; mode < 2; mode++) begin
            cfg_overwrite = mode[0];
            cfg_gpi_lock_mode = 1'b0;
            lock_active = 1'b0;
            do_reset();
            // R6: pop on empty
            do_op(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R6");
            // R2 fill, then R3 / R4 pushes into full
            for (int i = 0; i < DEPTH + 3; i++)
                do_op(1'b1, {i[0], 7'(i + 1)}, 1'b0, 1'b0, 1'b0,
                      (i < DEPTH) ? "R2" : (mode == 0 ? "R3" : "R4"));
            // R5: sticky, then clear
            do_op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R5");
            do_op(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R5");
            // R5: set and clear together, set wins
            do_op(1'b1, 8'h7E, 1'b0, 1'b0, 1'b1, "R5");
            do_op(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R5");
            // R7: push and pop together on full
            do_op(1'b1, 8'hC5, 1'b0, 1'b1, 1'b0, "R7");
            do_op(1'b1, 8'h45, 1'b1, 1'b1, 1'b0, "R7");
            // drain, one extra pop returns zero
            for (int i = 0; i < DEPTH + 1; i++)
                do_op(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, (i < DEPTH) ? "R2" : "R6");
            // R11: push and pop together on empty
            do_op(1'b1, 8'hB3, 1'b0, 1'b1, 1'b0, "R11");
            do_op(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R11");
            // R8 / R9 sweep over mask, lock and event class
            for (int k = 0; k < 8; k++) begin
                cfg_gpi_lock_mode = k[2];
                lock_active = k[1];
                do_op(1'b1, {k[0], 7'(k + 40)}, k[0], 1'b0, 1'b0, k[2] ? "R9" : "R8");
                do_op(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, k[2] ? "R9" : "R8");
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule